// File: doc/BRIEF.md
# Brainfuck Opcode Execution Core

This block runs a Brainfuck program one opcode at a time. A host holds the program and its counter logic. It presents a 3-bit opcode with a valid strobe. The core applies the opcode to its current data byte and to its 10-bit tape pointer. It also keeps its own 10-bit program counter, which advances by one on every accepted opcode.

Loops are handled jointly with the host. The core keeps a stack of loop-start addresses. When a loop must be skipped, the core raises a jump interrupt and waits for the host to deliver the target address through a 10-bit receive port. When a loop must repeat, the core raises the same interrupt and hands the top stack entry to a 10-bit transmit port. Moves along the tape go to a cache through a request/acknowledge port, which writes back the old byte and returns the new one. Input and output opcodes raise a separate interrupt.

A new opcode is taken only while `busy` is low.

Top module: `bf_core`

## Requirements
- R1: After reset the program counter, tape pointer and data byte are zero, and `busy`, `stack_err`, `jump_irq`, `io_irq`, `tape_req`, `tx_req` and `rx_en` are all low.
- R2: Opcode 001 adds one to the data byte and opcode 000 subtracts one, both modulo 256; the program counter advances by one.
- R3: Opcode 011 adds one to the pointer and opcode 010 subtracts one, both modulo 1024. After the move, `tape_req` stays high with `tape_ptr` equal to the new pointer and `tape_wdata` equal to the old byte until `tape_ack`; on the acknowledge the data byte becomes `tape_rdata`.
- R4: Opcode 100 with a nonzero data byte pushes the opcode's own program counter onto the stack and continues.
- R5: Opcode 100 with a zero data byte holds `jump_irq` and `rx_en` high until `rx_valid`; the program counter then becomes `rx_word`.
- R6: Opcode 101 with a zero data byte pops the stack and continues.
- R7: Opcode 101 with a nonzero data byte and a non-empty stack holds `jump_irq` and `tx_req` high with `tx_word` equal to the top entry until `tx_ack`. The stack is not popped, and the program counter becomes the top entry plus one.
- R8: Opcodes 110 (input) and 111 (output) hold `io_irq` high until `io_ack`, with `io_write` low for 110 and high for 111, and `io_wdata` equal to the data byte. For 110 the data byte becomes `io_rdata` on the acknowledge.
- R9: The stack holds 8 entries. A push onto a full stack, a pop from an empty stack, or opcode 101 with a nonzero byte on an empty stack sets `stack_err`, which stays set until reset. The stack is left unchanged, and in the last case no interrupt is raised and execution continues.
- R10: While a tape, serial or I/O transfer is pending, `busy` is high and `op_valid` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Opcode strobe |
| op_code | input | 3 | Opcode |
| busy | output | 1 | Transfer pending, opcodes ignored |
| pc | output | 10 | Program counter |
| ptr | output | 10 | Tape pointer |
| data | output | 8 | Current data byte |
| stack_err | output | 1 | Sticky stack misuse flag |
| jump_irq | output | 1 | Host must exchange a program counter |
| io_irq | output | 1 | Host must service input or output |
| tape_req | output | 1 | Cache refill request |
| tape_ptr | output | 10 | New pointer for the cache |
| tape_wdata | output | 8 | Byte to write back |
| tape_ack | input | 1 | Cache refill done |
| tape_rdata | input | 8 | Byte at the new pointer |
| tx_req | output | 1 | Transmit request |
| tx_word | output | 10 | Word to transmit |
| tx_ack | input | 1 | Transmit done |
| rx_en | output | 1 | Receiver enabled |
| rx_valid | input | 1 | Received word valid |
| rx_word | input | 10 | Received word |
| io_write | output | 1 | 1 for output, 0 for input |
| io_wdata | output | 8 | Byte to output |
| io_ack | input | 1 | I/O service done |
| io_rdata | input | 8 | Byte read from the host |

## Verification
Every accepted opcode, and every acknowledge, takes effect on the clock edge where it is sampled. The new counter, pointer, byte, request and interrupt values can therefore be read half a period later. The bench drives inputs on the falling edge and reads outputs on the next falling edge. During multi-cycle handshakes it stalls for a random number of cycles and re-checks the held requests on each falling edge. During those stalls it keeps a stray opcode on the port, which must be ignored.

// File: rtl/bf_pkg.sv
package bf_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_TAPE, ST_RX, ST_TX, ST_IO
  } core_st_e;

  typedef struct packed {
    logic data_op;
    logic ptr_op;
    logic up;
    logic loop_open;
    logic loop_close;
    logic io_op;
    logic io_write;
  } op_dec_t;
endpackage

// File: rtl/bf_decode.sv
module bf_decode
  import bf_pkg::*;
(
  input  logic [2:0] op,
  output op_dec_t    dec
);
  always_comb begin
    dec            = '0;
    dec.up         = op[0];
    dec.io_write   = op[0];
    unique case (op[2:1])
      2'b00: dec.data_op = 1'b1;
      2'b01: dec.ptr_op  = 1'b1;
      2'b10: begin
        dec.loop_open  = ~op[0];
        dec.loop_close = op[0];
      end
      default: dec.io_op = 1'b1;
    endcase
  end
endmodule

// File: rtl/bf_loop_stack.sv
module bf_loop_stack #(
  parameter int DEPTH = 8,
  parameter int AW    = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [AW-1:0] din,
  output logic [AW-1:0] top,
  output logic          full,
  output logic          empty
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0] count;
  logic [AW-1:0] ents [DEPTH];
  logic [IW-1:0] wr_idx, rd_idx;
  logic          do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty && !push;
  assign wr_idx  = count[IW-1:0];
  assign rd_idx  = IW'(count - 1'b1);
  assign top     = ents[rd_idx];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic [AW-1:0] val;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              val <= '0;
      else if (do_push && wr_idx == IW'(i))    val <= din;
    end
    assign ents[i] = val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       count <= '0;
    else if (do_push) count <= count + 1'b1;
    else if (do_pop)  count <= count - 1'b1;
  end

  a_r4_push_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !full) |=> count == $past(count) + 1'b1);
  a_r6_pop_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && !empty) |=> count == $past(count) - 1'b1);
  a_r9_full_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full) |=> count == $past(count));
  a_r9_empty_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && empty) |=> count == $past(count));
endmodule

// File: rtl/bf_core.sv
module bf_core
  import bf_pkg::*;
#(
  parameter int DW          = 8,
  parameter int AW          = 10,
  parameter int STACK_DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic [2:0]    op_code,
  output logic          busy,
  output logic [AW-1:0] pc,
  output logic [AW-1:0] ptr,
  output logic [DW-1:0] data,
  output logic          stack_err,
  output logic          jump_irq,
  output logic          io_irq,
  output logic          tape_req,
  output logic [AW-1:0] tape_ptr,
  output logic [DW-1:0] tape_wdata,
  input  logic          tape_ack,
  input  logic [DW-1:0] tape_rdata,
  output logic          tx_req,
  output logic [AW-1:0] tx_word,
  input  logic          tx_ack,
  output logic          rx_en,
  input  logic          rx_valid,
  input  logic [AW-1:0] rx_word,
  output logic          io_write,
  output logic [DW-1:0] io_wdata,
  input  logic          io_ack,
  input  logic [DW-1:0] io_rdata
);
  function automatic logic [DW-1:0] f_byte_step(input logic [DW-1:0] b, input logic up);
    return up ? b + 1'b1 : b - 1'b1;
  endfunction

  function automatic logic [AW-1:0] f_ptr_step(input logic [AW-1:0] p, input logic up);
    return up ? p + 1'b1 : p - 1'b1;
  endfunction

  core_st_e      state_q, state_d;
  op_dec_t       dec;
  logic [AW-1:0] pc_q, ptr_q, stk_top;
  logic [DW-1:0] data_q;
  logic          err_q, io_dir_q, stk_full, stk_empty, is_zero, accept;

  bf_decode u_dec (.op(op_code), .dec(dec));

  // named events
  logic ev_step, ev_move, ev_push, ev_fwd, ev_pop, ev_back, ev_orphan, ev_io;
  logic ev_overflow, ev_underflow, ev_tape_done, ev_rx_done, ev_tx_done, ev_io_done;

  assign accept       = op_valid && (state_q == ST_IDLE);
  assign is_zero      = (data_q == '0);
  assign ev_step      = accept && dec.data_op;
  assign ev_move      = accept && dec.ptr_op;
  assign ev_push      = accept && dec.loop_open && !is_zero;
  assign ev_fwd       = accept && dec.loop_open && is_zero;
  assign ev_pop       = accept && dec.loop_close && is_zero;
  assign ev_back      = accept && dec.loop_close && !is_zero && !stk_empty;
  assign ev_orphan    = accept && dec.loop_close && !is_zero && stk_empty;
  assign ev_io        = accept && dec.io_op;
  assign ev_overflow  = ev_push && stk_full;
  assign ev_underflow = ev_pop && stk_empty;
  assign ev_tape_done = (state_q == ST_TAPE) && tape_ack;
  assign ev_rx_done   = (state_q == ST_RX) && rx_valid;
  assign ev_tx_done   = (state_q == ST_TX) && tx_ack;
  assign ev_io_done   = (state_q == ST_IO) && io_ack;

  bf_loop_stack #(.DEPTH(STACK_DEPTH), .AW(AW)) u_stack (
    .clk(clk), .rst_n(rst_n), .push(ev_push), .pop(ev_pop), .din(pc_q),
    .top(stk_top), .full(stk_full), .empty(stk_empty)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (ev_move)      state_d = ST_TAPE;
        else if (ev_fwd)  state_d = ST_RX;
        else if (ev_back) state_d = ST_TX;
        else if (ev_io)   state_d = ST_IO;
      end
      ST_TAPE: if (tape_ack) state_d = ST_IDLE;
      ST_RX:   if (rx_valid) state_d = ST_IDLE;
      ST_TX:   if (tx_ack)   state_d = ST_IDLE;
      default: if (io_ack)   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      pc_q     <= '0;
      ptr_q    <= '0;
      data_q   <= '0;
      err_q    <= 1'b0;
      io_dir_q <= 1'b0;
    end else begin
      state_q <= state_d;
      err_q   <= err_q | ev_overflow | ev_underflow | ev_orphan;
      if (accept)          pc_q <= pc_q + 1'b1;
      else if (ev_rx_done) pc_q <= rx_word;
      else if (ev_tx_done) pc_q <= stk_top + 1'b1;
      if (ev_move) ptr_q <= f_ptr_step(ptr_q, dec.up);
      if (ev_step)                       data_q <= f_byte_step(data_q, dec.up);
      else if (ev_tape_done)             data_q <= tape_rdata;
      else if (ev_io_done && !io_dir_q)  data_q <= io_rdata;
      if (ev_io) io_dir_q <= dec.io_write;
    end
  end

  assign busy       = (state_q != ST_IDLE);
  assign pc         = pc_q;
  assign ptr        = ptr_q;
  assign data       = data_q;
  assign stack_err  = err_q;
  assign tape_req   = (state_q == ST_TAPE);
  assign tape_ptr   = ptr_q;
  assign tape_wdata = data_q;
  assign rx_en      = (state_q == ST_RX);
  assign tx_req     = (state_q == ST_TX);
  assign tx_word    = stk_top;
  assign jump_irq   = rx_en || tx_req;
  assign io_irq     = (state_q == ST_IO);
  assign io_write   = io_dir_q;
  assign io_wdata   = data_q;

  a_r3_tape_held: assert property (@(posedge clk) disable iff (!rst_n)
    (tape_req && !tape_ack) |=> tape_req && $stable(tape_ptr) && $stable(tape_wdata));
  a_r7_tx_held: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_req && !tx_ack) |=> tx_req && $stable(tx_word));
  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    stack_err |=> stack_err);
  a_r10_busy_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !rx_valid && !tx_ack) |=> $stable(pc));
  a_r8_irq_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    io_irq |-> !jump_irq && !tape_req);
endmodule

// File: tb/bf_core_tb.sv
module bf_core_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_valid = 1'b0;
  logic [2:0] op_code = '0;
  logic busy, stack_err, jump_irq, io_irq, tape_req, tx_req, rx_en, io_write;
  logic [9:0] pc, ptr, tape_ptr, tx_word;
  logic [7:0] data, tape_wdata, io_wdata;
  logic tape_ack = 0, tx_ack = 0, rx_valid = 0, io_ack = 0;
  logic [7:0] tape_rdata = '0, io_rdata = '0;
  logic [9:0] rx_word = '0;

  int checks = 0, errors = 0, cycles = 0;
  logic [9:0] m_pc, m_ptr;
  logic [7:0] m_data;
  logic       m_err;
  logic [9:0] m_stk [8];
  int         m_sp;

  always #2.5 clk = ~clk;

  bf_core u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code), .busy(busy),
    .pc(pc), .ptr(ptr), .data(data), .stack_err(stack_err), .jump_irq(jump_irq),
    .io_irq(io_irq), .tape_req(tape_req), .tape_ptr(tape_ptr), .tape_wdata(tape_wdata),
    .tape_ack(tape_ack), .tape_rdata(tape_rdata), .tx_req(tx_req), .tx_word(tx_word),
    .tx_ack(tx_ack), .rx_en(rx_en), .rx_valid(rx_valid), .rx_word(rx_word),
    .io_write(io_write), .io_wdata(io_wdata), .io_ack(io_ack), .io_rdata(io_rdata)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: act %0d cycles exp below 100000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic [7:0] ref_byte(input logic [7:0] b, input logic up);
    int v = int'(b) + (up ? 1 : 255);
    return 8'(v % 256);
  endfunction

  function automatic logic [9:0] ref_ptr(input logic [9:0] p, input logic up);
    int v = int'(p) + (up ? 1 : 1023);
    return 10'(v % 1024);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: act %0d exp %0d", req, act, exp);
    end
  endtask

  task automatic check_state(input string req);
    check({req, " pc"}, pc, m_pc);
    check({req, " ptr"}, ptr, m_ptr);
    check({req, " data"}, data, m_data);
    check({req, " err"}, stack_err, m_err);
    check({req, " busy"}, busy, 0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    m_pc = '0; m_ptr = '0; m_data = '0; m_err = 1'b0; m_sp = 0;
    @(negedge clk);
  endtask

  // stall cycles with a stray '+' on the port that must be ignored (R10)
  task automatic stall_with_stray(input int n, input string req);
    repeat (n) begin
      op_valid = 1'b1; op_code = 3'b001;
      @(negedge clk);
      check({req, " R10 busy held"}, busy, 1);
    end
    op_valid = 1'b0;
  endtask

  task automatic run_op(input logic [2:0] c, input int stall, input logic [9:0] word,
                        input logic [7:0] byt);
    logic zero;
    logic [7:0] old;
    zero = (m_data == 0);
    old  = m_data;
    op_valid = 1'b1; op_code = c;
    @(negedge clk);
    op_valid = 1'b0;
    m_pc = m_pc + 10'd1;
    case (c)
      3'b000, 3'b001: begin
        m_data = ref_byte(m_data, c[0]);
        check_state("R2");
      end
      3'b010, 3'b011: begin
        m_ptr = ref_ptr(m_ptr, c[0]);
        check("R3 tape_req", tape_req, 1);
        check("R3 tape_ptr", tape_ptr, m_ptr);
        check("R3 tape_wdata", tape_wdata, old);
        stall_with_stray(stall, "R3");
        check("R3 tape_req held", tape_req, 1);
        tape_ack = 1'b1; tape_rdata = byt;
        @(negedge clk);
        tape_ack = 1'b0;
        m_data = byt;
        check_state("R3");
      end
      3'b100: begin
        if (zero) begin
          check("R5 jump_irq", jump_irq, 1);
          check("R5 rx_en", rx_en, 1);
          stall_with_stray(stall, "R5");
          rx_valid = 1'b1; rx_word = word;
          @(negedge clk);
          rx_valid = 1'b0;
          m_pc = word;
          check("R5 rx_en low", rx_en, 0);
          check_state("R5");
        end else begin
          if (m_sp == 8) m_err = 1'b1;
          else begin m_stk[m_sp] = m_pc - 10'd1; m_sp++; end
          check("R4 no irq", jump_irq, 0);
          check_state(m_err ? "R9/R4" : "R4");
        end
      end
      3'b101: begin
        if (zero) begin
          if (m_sp == 0) m_err = 1'b1; else m_sp--;
          check_state("R6");
        end else if (m_sp == 0) begin
          m_err = 1'b1;
          check("R9 orphan no irq", jump_irq, 0);
          check_state("R9");
        end else begin
          check("R7 jump_irq", jump_irq, 1);
          check("R7 tx_req", tx_req, 1);
          check("R7 tx_word", tx_word, m_stk[m_sp-1]);
          stall_with_stray(stall, "R7");
          tx_ack = 1'b1;
          @(negedge clk);
          tx_ack = 1'b0;
          m_pc = m_stk[m_sp-1] + 10'd1;
          check("R7 tx_req low", tx_req, 0);
          check_state("R7");
        end
      end
      default: begin
        check("R8 io_irq", io_irq, 1);
        check("R8 io_write", io_write, c[0]);
        check("R8 io_wdata", io_wdata, old);
        check("R8 jump_irq low", jump_irq, 0);
        stall_with_stray(stall, "R8");
        io_ack = 1'b1; io_rdata = byt;
        @(negedge clk);
        io_ack = 1'b0;
        if (!c[0]) m_data = byt;
        check("R8 io_irq low", io_irq, 0);
        check_state("R8");
      end
    endcase
  endtask

  initial begin
    void'($urandom(32'd20240611));
    m_pc = '0; m_ptr = '0; m_data = '0; m_err = 1'b0; m_sp = 0;
    do_reset();
    // R1 reset state
    check_state("R1");
    check("R1 jump_irq", jump_irq, 0);
    check("R1 io_irq", io_irq, 0);
    check("R1 tape_req", tape_req, 0);
    check("R1 tx_req", tx_req, 0);
    check("R1 rx_en", rx_en, 0);

    // R2 wrap below zero and back
    run_op(3'b000, 0, '0, '0);
    check("R2 wrap 255", data, 255);
    run_op(3'b001, 0, '0, '0);
    // R3 pointer wraps below zero, with stalls
    run_op(3'b010, 2, '0, 8'd7);
    check("R3 wrap 1023", ptr, 1023);
    run_op(3'b011, 1, '0, 8'd0);
    // R5 forward jump with zero byte
    run_op(3'b100, 3, 10'd40, '0);
    // R4, R8, R7, R6 loop round trip
    run_op(3'b001, 0, '0, '0);
    run_op(3'b100, 0, '0, '0);
    run_op(3'b111, 1, '0, '0);
    run_op(3'b110, 2, '0, 8'd9);
    run_op(3'b101, 2, '0, '0);
    check("R7 pc after back jump", pc, 42);
    run_op(3'b000, 0, '0, '0);
    run_op(3'b000, 0, '0, '0);
    run_op(3'b000, 0, '0, '0);
    run_op(3'b000, 0, '0, '0);
    run_op(3'b000, 0, '0, '0);
    run_op(3'b000, 0, '0, '0);
    run_op(3'b000, 0, '0, '0);
    run_op(3'b000, 0, '0, '0);
    run_op(3'b000, 0, '0, '0);
    check("R2 data zero", data, 0);
    run_op(3'b101, 0, '0, '0);
    // R9 pop from empty
    run_op(3'b101, 0, '0, '0);
    check("R9 underflow flag", stack_err, 1);
    do_reset();
    check("R1 err cleared", stack_err, 0);
    // R9 overflow on ninth push, then back jump to eighth entry
    run_op(3'b001, 0, '0, '0);
    for (int i = 0; i < 9; i++) run_op(3'b100, 0, '0, '0);
    check("R9 overflow flag", stack_err, 1);
    run_op(3'b101, 1, '0, '0);
    check("R9 top kept after overflow", pc, 9);
    // R9 orphan close
    do_reset();
    run_op(3'b001, 0, '0, '0);
    run_op(3'b101, 0, '0, '0);

    // constrained random phase
    do_reset();
    for (int n = 0; n < 600; n++) begin
      logic [2:0] c;
      logic [7:0] b;
      c = 3'($urandom_range(0, 7));
      b = ($urandom_range(0, 1) == 0) ? 8'd0 : 8'($urandom);
      run_op(c, $urandom_range(0, 3), 10'($urandom), b);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule